// File: doc/BRIEF.md
# Two-Processor MSI Snooping Coherence Controller

This block models two processors sharing one bus, each with a write-back cache of exactly one line of two 32-bit words, backed by a shared 512-word memory. A request carries a processor number, a read/write flag and a word-aligned byte address. The block runs the requesting cache through its MSI transition. It then applies the snoop response in the other cache and performs any write-backs into memory. When it finishes, it reports the bus action, the contents of both caches and the running statistics.

A write is modelled as an increment of the addressed word. A snooping cache that holds the line Modified supplies its data in the same bus action as the request, so the action is reported as a combined read or read-for-ownership with write-back. A requester that must evict a dirty line first performs a replacement write-back. This write-back is flagged on its own output in the same completion cycle.

Top module: `msi_pair_ctrl`

## Requirements
- R1: After reset both lines are Invalid with tag 0 and words 0, every counter is 0, done and error are low, and every memory word reads back as zero on a later refill.
- R2: req_ready is high when idle. After a request is accepted it is low until completion. done_o is a one-cycle pulse that carries the bus action on act_o, encoded as NONE=0, READ=1, RIM=2, INV=3, RD_WB=4, RIM_WB=5.
- R3: A read miss, with the line Invalid or Shared, loads the line from memory, leaves it Shared (state code 1) and reports READ.
- R4: A write miss, with the line Invalid or Shared, loads the line, increments the addressed word, leaves the line Modified (state code 2) and reports RIM.
- R5: A read hit in Shared or Modified, or a write hit in Modified, reports NONE and keeps the state. A write hit increments the addressed word.
- R6: A write hit in Shared moves the line to Modified, increments the word and reports INV.
- R7: A miss while the requester's own line is Modified raises wbr_o and writes the old line to memory before the refill. The bus action that follows is READ or RIM (or its combined form).
- R8: When the other cache's line matches, the snooper responds as follows. Shared stays Shared on READ and becomes Invalid (code 0) on RIM or INV. Modified on READ writes back, becomes Shared and turns the action into RD_WB. Modified on RIM writes back, becomes Invalid and turns the action into RIM_WB. A line with a different tag is left unchanged.
- R9: Byte address bit 2 selects word 1 (set) or word 0 (clear) of the line. The reported tag is the byte address shifted right by 3.
- R10: Each processor has four counters: read hits, read misses, write hits and write misses. Each request increments exactly one of them.
- R11: A bus counter is kept for each of READ, RIM, WB and INV. RD_WB counts as one READ plus one WB, RIM_WB counts as one RIM plus one WB, and a replacement write-back counts as one WB. The total equals the sum of the four.
- R12: err_o goes high and stays high if a snooped INV meets a Modified line, or if one cache holds a line Modified while the other holds the same line. Under legal traffic err_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_proc | input | 1 | Requesting processor |
| req_wr | input | 1 | 1 = write (increment), 0 = read |
| req_addr | input | ABITS | Word-aligned byte address |
| done_o | output | 1 | Completion pulse |
| act_o | output | 3 | Bus action of the last request |
| wbr_o | output | 1 | Replacement write-back occurred in the last request |
| err_o | output | 1 | Sticky illegal-condition flag |
| c0_state | output | 2 | Cache 0 state (I=0, S=1, M=2) |
| c0_tag | output | ABITS-3 | Cache 0 line address |
| c0_word0 | output | WW | Cache 0 word 0 |
| c0_word1 | output | WW | Cache 0 word 1 |
| c1_state | output | 2 | Cache 1 state |
| c1_tag | output | ABITS-3 | Cache 1 line address |
| c1_word0 | output | WW | Cache 1 word 0 |
| c1_word1 | output | WW | Cache 1 word 1 |
| rd_hit_o | output | 2xCW | Read hits per processor |
| rd_miss_o | output | 2xCW | Read misses per processor |
| wr_hit_o | output | 2xCW | Write hits per processor |
| wr_miss_o | output | 2xCW | Write misses per processor |
| bus_read_o | output | CW | READ count |
| bus_rim_o | output | CW | RIM count |
| bus_wb_o | output | CW | Write-back count |
| bus_inv_o | output | CW | INV count |
| bus_total_o | output | CW | Sum of bus counts |

## Verification
A wrong line state shows up at the next request to the same line. A line wrongly kept Shared turns a later write hit into an unexpected INV. A line wrongly dropped to Invalid turns a hit into a miss and bumps the miss counter. Both are visible on the very next done pulse. A lost write-back is visible only later, when the other cache refills the line and its words come back stale. The sequences therefore follow every write-back with a refill of that line, and compare both caches' words after each request.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2} line_st_t;
  typedef enum logic [2:0] {
    BA_NONE  = 3'd0,
    BA_READ  = 3'd1,
    BA_RIM   = 3'd2,
    BA_INV   = 3'd3,
    BA_RDWB  = 3'd4,
    BA_RIMWB = 3'd5
  } bus_act_t;
  typedef enum logic [1:0] {SQ_IDLE, SQ_LOOK, SQ_SNOOP, SQ_FILL} seq_t;
endpackage

// File: rtl/msi_snoop_resp.sv
module msi_snoop_resp
  import msi_pkg::*;
#(
  parameter int LBITS = 8
) (
  input  line_st_t         st_i,
  input  logic [LBITS-1:0] tag_i,
  input  logic [LBITS-1:0] bus_tag_i,
  input  bus_act_t         act_i,
  output line_st_t         st_o,
  output logic             wb_o,
  output bus_act_t         act_o,
  output logic             err_o
);
  logic match;
  assign match = (st_i != ST_I) && (tag_i == bus_tag_i);

  always_comb begin
    st_o  = st_i;
    wb_o  = 1'b0;
    act_o = act_i;
    err_o = 1'b0;
    if (match) begin
      unique case (st_i)
        ST_S: if (act_i == BA_RIM || act_i == BA_INV) st_o = ST_I;
        ST_M: begin
          unique case (act_i)
            BA_READ: begin st_o = ST_S; wb_o = 1'b1; act_o = BA_RDWB;  end
            BA_RIM:  begin st_o = ST_I; wb_o = 1'b1; act_o = BA_RIMWB; end
            BA_INV:  err_o = 1'b1;
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/msi_backing_mem.sv
module msi_backing_mem #(
  parameter int WW    = 32,
  parameter int LBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LBITS-1:0] wr_line,
  input  logic [WW-1:0]    wr_w0,
  input  logic [WW-1:0]    wr_w1,
  input  logic [LBITS-1:0] rd_line,
  output logic [WW-1:0]    rd_w0,
  output logic [WW-1:0]    rd_w1
);
  localparam int LINES = 1 << LBITS;

  logic [LINES-1:0] vld_q;
  logic [WW-1:0]    m0 [LINES];
  logic [WW-1:0]    m1 [LINES];

  // Written lines are marked valid; unwritten lines read as zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[wr_line] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      m0[wr_line] <= wr_w0;
      m1[wr_line] <= wr_w1;
    end
  end

  assign rd_w0 = vld_q[rd_line] ? m0[rd_line] : '0;
  assign rd_w1 = vld_q[rd_line] ? m1[rd_line] : '0;
endmodule

// File: rtl/msi_stats.sv
module msi_stats
  import msi_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_en,
  input  logic                req_proc,
  input  logic                req_hit,
  input  logic                req_wr,
  input  logic                bus_en,
  input  bus_act_t            bus_act,
  input  logic                wbr_ev,
  output logic [1:0][CW-1:0]  rd_hit_o,
  output logic [1:0][CW-1:0]  rd_miss_o,
  output logic [1:0][CW-1:0]  wr_hit_o,
  output logic [1:0][CW-1:0]  wr_miss_o,
  output logic [CW-1:0]       bus_read_o,
  output logic [CW-1:0]       bus_rim_o,
  output logic [CW-1:0]       bus_wb_o,
  output logic [CW-1:0]       bus_inv_o,
  output logic [CW-1:0]       bus_total_o
);
  for (genvar p = 0; p < 2; p++) begin : g_proc
    logic sel;
    assign sel = req_en && (req_proc == p[0]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_hit_o[p]  <= '0;
        rd_miss_o[p] <= '0;
        wr_hit_o[p]  <= '0;
        wr_miss_o[p] <= '0;
      end else if (sel) begin
        if (!req_wr &&  req_hit) rd_hit_o[p]  <= rd_hit_o[p]  + 1'b1;
        if (!req_wr && !req_hit) rd_miss_o[p] <= rd_miss_o[p] + 1'b1;
        if ( req_wr &&  req_hit) wr_hit_o[p]  <= wr_hit_o[p]  + 1'b1;
        if ( req_wr && !req_hit) wr_miss_o[p] <= wr_miss_o[p] + 1'b1;
      end
    end
  end

  logic inc_rd, inc_rim, inc_inv, inc_wb;
  logic [1:0] inc_tot;

  always_comb begin
    inc_rd  = bus_en && (bus_act == BA_READ || bus_act == BA_RDWB);
    inc_rim = bus_en && (bus_act == BA_RIM  || bus_act == BA_RIMWB);
    inc_inv = bus_en && (bus_act == BA_INV);
    inc_wb  = wbr_ev || (bus_en && (bus_act == BA_RDWB || bus_act == BA_RIMWB));
    inc_tot = 2'(inc_rd) + 2'(inc_rim) + 2'(inc_inv) + 2'(inc_wb);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_read_o  <= '0;
      bus_rim_o   <= '0;
      bus_wb_o    <= '0;
      bus_inv_o   <= '0;
      bus_total_o <= '0;
    end else begin
      if (inc_rd)  bus_read_o <= bus_read_o + 1'b1;
      if (inc_rim) bus_rim_o  <= bus_rim_o  + 1'b1;
      if (inc_wb)  bus_wb_o   <= bus_wb_o   + 1'b1;
      if (inc_inv) bus_inv_o  <= bus_inv_o  + 1'b1;
      if (inc_tot != 2'd0) bus_total_o <= bus_total_o + CW'(inc_tot);
    end
  end

  // R11: a combined action moves the total by two.
  assert_total_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && (bus_act == BA_RDWB || bus_act == BA_RIMWB))
      |=> (bus_total_o == $past(bus_total_o) + CW'(2)));
endmodule

// File: rtl/msi_pair_ctrl.sv
module msi_pair_ctrl
  import msi_pkg::*;
#(
  parameter int WW    = 32,
  parameter int ABITS = 11,
  parameter int CW    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_proc,
  input  logic                  req_wr,
  input  logic [ABITS-1:0]      req_addr,
  output logic                  done_o,
  output logic [2:0]            act_o,
  output logic                  wbr_o,
  output logic                  err_o,
  output logic [1:0]            c0_state,
  output logic [ABITS-4:0]      c0_tag,
  output logic [WW-1:0]         c0_word0,
  output logic [WW-1:0]         c0_word1,
  output logic [1:0]            c1_state,
  output logic [ABITS-4:0]      c1_tag,
  output logic [WW-1:0]         c1_word0,
  output logic [WW-1:0]         c1_word1,
  output logic [1:0][CW-1:0]    rd_hit_o,
  output logic [1:0][CW-1:0]    rd_miss_o,
  output logic [1:0][CW-1:0]    wr_hit_o,
  output logic [1:0][CW-1:0]    wr_miss_o,
  output logic [CW-1:0]         bus_read_o,
  output logic [CW-1:0]         bus_rim_o,
  output logic [CW-1:0]         bus_wb_o,
  output logic [CW-1:0]         bus_inv_o,
  output logic [CW-1:0]         bus_total_o
);
  localparam int LBITS = ABITS - 3;

  // Sequencer and captured request
  seq_t             seq_q, seq_n;
  logic             rq_proc, rq_wr, rq_sel;
  logic [LBITS-1:0] rq_line;
  logic             cap_en;
  logic             hit_q, hit_n, wbr_q, wbr_n, done_q, done_n, err_q, err_n;
  bus_act_t         act_q, act_n;

  // Cache lines
  line_st_t         st_q [2];
  line_st_t         st_n [2];
  logic [LBITS-1:0] tag_q [2];
  logic [LBITS-1:0] tag_n [2];
  logic [WW-1:0]    w0_q [2];
  logic [WW-1:0]    w0_n [2];
  logic [WW-1:0]    w1_q [2];
  logic [WW-1:0]    w1_n [2];

  // Memory port
  logic             mem_we;
  logic [LBITS-1:0] mem_wl;
  logic [WW-1:0]    mem_w0, mem_w1, mem_r0, mem_r1;

  // Stats strobes
  logic             cnt_en, bus_en, wbr_ev;

  logic             own, oth, own_hit, pair_bad;
  bus_act_t         raw_act, sn_act;
  line_st_t         sn_st;
  logic             sn_wb, sn_err;
  logic [WW-1:0]    base0, base1;

  assign own      = rq_proc;
  assign oth      = ~rq_proc;
  assign own_hit  = (st_q[own] != ST_I) && (tag_q[own] == rq_line);
  assign pair_bad = (st_q[0] != ST_I) && (st_q[1] != ST_I) && (tag_q[0] == tag_q[1])
                    && ((st_q[0] == ST_M) || (st_q[1] == ST_M));

  // Requester's bus intent, from the hit result latched in the lookup cycle
  always_comb begin
    if (!hit_q)                         raw_act = rq_wr ? BA_RIM : BA_READ;
    else if (rq_wr && st_q[own] == ST_S) raw_act = BA_INV;
    else                                raw_act = BA_NONE;
  end

  msi_snoop_resp #(.LBITS(LBITS)) u_snoop (
    .st_i      (st_q[oth]),
    .tag_i     (tag_q[oth]),
    .bus_tag_i (rq_line),
    .act_i     (raw_act),
    .st_o      (sn_st),
    .wb_o      (sn_wb),
    .act_o     (sn_act),
    .err_o     (sn_err)
  );

  msi_backing_mem #(.WW(WW), .LBITS(LBITS)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mem_we),
    .wr_line (mem_wl),
    .wr_w0   (mem_w0),
    .wr_w1   (mem_w1),
    .rd_line (rq_line),
    .rd_w0   (mem_r0),
    .rd_w1   (mem_r1)
  );

  assign base0 = hit_q ? w0_q[own] : mem_r0;
  assign base1 = hit_q ? w1_q[own] : mem_r1;

  // Next-state process
  always_comb begin
    seq_n  = seq_q;
    st_n   = st_q;
    tag_n  = tag_q;
    w0_n   = w0_q;
    w1_n   = w1_q;
    hit_n  = hit_q;
    wbr_n  = wbr_q;
    act_n  = act_q;
    done_n = 1'b0;
    err_n  = err_q | pair_bad;
    cap_en = 1'b0;
    cnt_en = 1'b0;
    bus_en = 1'b0;
    wbr_ev = 1'b0;
    mem_we = 1'b0;
    mem_wl = '0;
    mem_w0 = '0;
    mem_w1 = '0;
    unique case (seq_q)
      SQ_IDLE: begin
        if (req_valid) begin
          cap_en = 1'b1;
          wbr_n  = 1'b0;
          seq_n  = SQ_LOOK;
        end
      end
      SQ_LOOK: begin
        cnt_en = 1'b1;
        hit_n  = own_hit;
        if (!own_hit && st_q[own] == ST_M) begin
          mem_we = 1'b1;
          mem_wl = tag_q[own];
          mem_w0 = w0_q[own];
          mem_w1 = w1_q[own];
          wbr_n  = 1'b1;
          wbr_ev = 1'b1;
        end
        seq_n = SQ_SNOOP;
      end
      SQ_SNOOP: begin
        bus_en     = 1'b1;
        st_n[oth]  = sn_st;
        act_n      = sn_act;
        if (sn_err) err_n = 1'b1;
        if (sn_wb) begin
          mem_we = 1'b1;
          mem_wl = tag_q[oth];
          mem_w0 = w0_q[oth];
          mem_w1 = w1_q[oth];
        end
        seq_n = SQ_FILL;
      end
      SQ_FILL: begin
        tag_n[own] = rq_line;
        w0_n[own]  = (rq_wr && !rq_sel) ? base0 + 1'b1 : base0;
        w1_n[own]  = (rq_wr &&  rq_sel) ? base1 + 1'b1 : base1;
        if (rq_wr)       st_n[own] = ST_M;
        else if (!hit_q) st_n[own] = ST_S;
        done_n = 1'b1;
        seq_n  = SQ_IDLE;
      end
      default: seq_n = SQ_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q   <= SQ_IDLE;
      rq_proc <= 1'b0;
      rq_wr   <= 1'b0;
      rq_sel  <= 1'b0;
      rq_line <= '0;
      hit_q   <= 1'b0;
      wbr_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      act_q   <= BA_NONE;
      for (int i = 0; i < 2; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
        w0_q[i]  <= '0;
        w1_q[i]  <= '0;
      end
    end else begin
      seq_q  <= seq_n;
      hit_q  <= hit_n;
      wbr_q  <= wbr_n;
      done_q <= done_n;
      err_q  <= err_n;
      act_q  <= act_n;
      if (cap_en) begin
        rq_proc <= req_proc;
        rq_wr   <= req_wr;
        rq_sel  <= req_addr[2];
        rq_line <= req_addr[ABITS-1:3];
      end
      st_q  <= st_n;
      tag_q <= tag_n;
      w0_q  <= w0_n;
      w1_q  <= w1_n;
    end
  end

  msi_stats #(.CW(CW)) u_stats (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_en      (cnt_en),
    .req_proc    (rq_proc),
    .req_hit     (own_hit),
    .req_wr      (rq_wr),
    .bus_en      (bus_en),
    .bus_act     (sn_act),
    .wbr_ev      (wbr_ev),
    .rd_hit_o    (rd_hit_o),
    .rd_miss_o   (rd_miss_o),
    .wr_hit_o    (wr_hit_o),
    .wr_miss_o   (wr_miss_o),
    .bus_read_o  (bus_read_o),
    .bus_rim_o   (bus_rim_o),
    .bus_wb_o    (bus_wb_o),
    .bus_inv_o   (bus_inv_o),
    .bus_total_o (bus_total_o)
  );

  assign req_ready = (seq_q == SQ_IDLE);
  assign done_o    = done_q;
  assign act_o     = act_q;
  assign wbr_o     = wbr_q;
  assign err_o     = err_q;
  assign c0_state  = st_q[0];
  assign c0_tag    = tag_q[0];
  assign c0_word0  = w0_q[0];
  assign c0_word1  = w1_q[0];
  assign c1_state  = st_q[1];
  assign c1_tag    = tag_q[1];
  assign c1_word0  = w0_q[1];
  assign c1_word1  = w1_q[1];

  // R2: an accepted request keeps the block busy in the next cycle
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R2: completion is a single-cycle pulse
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: only word-aligned addresses are presented
  assert_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[1:0] == 2'b00));

  // R7: a replacement write-back is always followed by a refill action
  assert_wbr_refill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && wbr_o) |-> (act_o == 3'd1 || act_o == 3'd2 || act_o == 3'd4 || act_o == 3'd5));

  // R8: a Modified line is never held alongside another copy
  assert_m_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !((c0_state == 2'd2 || c1_state == 2'd2) && c0_state != 2'd0 && c1_state != 2'd0
      && c0_tag == c1_tag && seq_q == SQ_IDLE));

  // R12: legal traffic never raises the error flag
  assert_no_err_R12: assert property (@(posedge clk) disable iff (!rst_n) !err_o);
endmodule

// File: tb/tb_msi_pair_ctrl.sv
`timescale 1ns/1ps
module tb_msi_pair_ctrl;
  localparam int WW = 32, ABITS = 11, CW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_proc, req_wr;
  logic [ABITS-1:0] req_addr;
  logic req_ready, done_o, wbr_o, err_o;
  logic [2:0] act_o;
  logic [1:0] c0_state, c1_state;
  logic [ABITS-4:0] c0_tag, c1_tag;
  logic [WW-1:0] c0_word0, c0_word1, c1_word0, c1_word1;
  logic [1:0][CW-1:0] rd_hit_o, rd_miss_o, wr_hit_o, wr_miss_o;
  logic [CW-1:0] bus_read_o, bus_rim_o, bus_wb_o, bus_inv_o, bus_total_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  msi_pair_ctrl #(.WW(WW), .ABITS(ABITS), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_proc(req_proc), .req_wr(req_wr), .req_addr(req_addr),
    .done_o(done_o), .act_o(act_o), .wbr_o(wbr_o), .err_o(err_o),
    .c0_state(c0_state), .c0_tag(c0_tag), .c0_word0(c0_word0), .c0_word1(c0_word1),
    .c1_state(c1_state), .c1_tag(c1_tag), .c1_word0(c1_word0), .c1_word1(c1_word1),
    .rd_hit_o(rd_hit_o), .rd_miss_o(rd_miss_o), .wr_hit_o(wr_hit_o), .wr_miss_o(wr_miss_o),
    .bus_read_o(bus_read_o), .bus_rim_o(bus_rim_o), .bus_wb_o(bus_wb_o),
    .bus_inv_o(bus_inv_o), .bus_total_o(bus_total_o)
  );

  localparam logic [2:0] A_NONE = 3'd0, A_READ = 3'd1, A_RIM = 3'd2,
                         A_INV = 3'd3, A_RDWB = 3'd4, A_RIMWB = 3'd5;
  localparam logic [1:0] SI = 2'd0, SS = 2'd1, SM = 2'd2;

  task automatic chk(input string rq, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0; req_proc = 1'b0; req_wr = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Issue one request and wait for the done pulse; samples at negedges.
  task automatic xfer(input bit p, input bit wr, input logic [ABITS-1:0] a,
                      input logic [2:0] exp_act, input bit exp_wbr, input string rq);
    int n;
    @(negedge clk);
    chk("R2", "ready idle", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_proc = p; req_wr = wr; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2", "ready busy", 64'(req_ready), 64'd0);
    n = 0;
    while (!done_o && n < 20) begin @(negedge clk); n++; end
    chk("R2", "done seen", 64'(done_o), 64'd1);
    chk(rq, "act", 64'(act_o), 64'(exp_act));
    chk(rq, "wbr", 64'(wbr_o), 64'(exp_wbr));
    chk("R12", "err", 64'(err_o), 64'd0);
  endtask

  task automatic chk_line(input bit p, input logic [1:0] st, input logic [7:0] tag,
                          input logic [31:0] w0, input logic [31:0] w1, input string rq);
    if (!p) begin
      chk(rq, "c0 state", 64'(c0_state), 64'(st));
      if (st != SI) begin
        chk(rq, "c0 tag", 64'(c0_tag), 64'(tag));
        chk(rq, "c0 w0", 64'(c0_word0), 64'(w0));
        chk(rq, "c0 w1", 64'(c0_word1), 64'(w1));
      end
    end else begin
      chk(rq, "c1 state", 64'(c1_state), 64'(st));
      if (st != SI) begin
        chk(rq, "c1 tag", 64'(c1_tag), 64'(tag));
        chk(rq, "c1 w0", 64'(c1_word0), 64'(w0));
        chk(rq, "c1 w1", 64'(c1_word1), 64'(w1));
      end
    end
  endtask

  task automatic chk_stats(input int p0[4], input int p1[4], input int bus[5]);
    chk("R10", "p0 rd hit",  64'(rd_hit_o[0]),  64'(p0[0]));
    chk("R10", "p0 rd miss", 64'(rd_miss_o[0]), 64'(p0[1]));
    chk("R10", "p0 wr hit",  64'(wr_hit_o[0]),  64'(p0[2]));
    chk("R10", "p0 wr miss", 64'(wr_miss_o[0]), 64'(p0[3]));
    chk("R10", "p1 rd hit",  64'(rd_hit_o[1]),  64'(p1[0]));
    chk("R10", "p1 rd miss", 64'(rd_miss_o[1]), 64'(p1[1]));
    chk("R10", "p1 wr hit",  64'(wr_hit_o[1]),  64'(p1[2]));
    chk("R10", "p1 wr miss", 64'(wr_miss_o[1]), 64'(p1[3]));
    chk("R11", "bus read",   64'(bus_read_o),   64'(bus[0]));
    chk("R11", "bus rim",    64'(bus_rim_o),    64'(bus[1]));
    chk("R11", "bus wb",     64'(bus_wb_o),     64'(bus[2]));
    chk("R11", "bus inv",    64'(bus_inv_o),    64'(bus[3]));
    chk("R11", "bus total",  64'(bus_total_o),  64'(bus[4]));
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1", "ready", 64'(req_ready), 64'd1);
    chk("R1", "done", 64'(done_o), 64'd0);
    chk("R1", "err", 64'(err_o), 64'd0);
    chk("R1", "c0", {c0_state, c0_tag, c0_word0, c0_word1} , 64'd0);
    chk("R1", "c1", {c1_state, c1_tag, c1_word0, c1_word1} , 64'd0);
    chk_stats('{0,0,0,0}, '{0,0,0,0}, '{0,0,0,0,0});
  endtask

  // Refills, upgrade, replacement write-backs and their memory effect.
  task automatic t_refill_chain();
    xfer(0, 0, 11'h100, A_READ, 0, "R3");
    chk_line(0, SS, 8'h20, 0, 0, "R3");
    xfer(0, 1, 11'h100, A_INV, 0, "R6");
    chk_line(0, SM, 8'h20, 1, 0, "R6");
    xfer(0, 0, 11'h200, A_READ, 1, "R7");
    chk_line(0, SS, 8'h40, 0, 0, "R7");
    xfer(1, 0, 11'h100, A_READ, 0, "R7");
    chk_line(1, SS, 8'h20, 1, 0, "R7");          // sees the written-back word
    xfer(0, 0, 11'h100, A_READ, 0, "R3");         // miss from S
    chk_line(0, SS, 8'h20, 1, 0, "R3");
    chk_line(1, SS, 8'h20, 1, 0, "R8");           // Shared snooper on READ stays
    xfer(1, 1, 11'h100, A_INV, 0, "R6");
    chk_line(1, SM, 8'h20, 2, 0, "R6");
    chk_line(0, SI, 0, 0, 0, "R8");               // Shared snooper on INV drops
    xfer(1, 1, 11'h300, A_RIM, 1, "R4");
    chk_line(1, SM, 8'h60, 1, 0, "R4");
    chk_stats('{0,3,1,0}, '{0,1,1,1}, '{4,1,2,2,9});
  endtask

  // Words of one line touched by both caches: combined write-back actions.
  task automatic t_false_share();
    do_reset();
    xfer(0, 0, 11'h100, A_READ, 0, "R1");
    chk_line(0, SS, 8'h20, 0, 0, "R1");           // memory cleared by reset
    xfer(0, 1, 11'h100, A_INV, 0, "R6");
    xfer(1, 0, 11'h104, A_RDWB, 0, "R8");
    chk_line(0, SS, 8'h20, 1, 0, "R8");
    chk_line(1, SS, 8'h20, 1, 0, "R8");
    xfer(1, 1, 11'h104, A_INV, 0, "R9");
    chk_line(1, SM, 8'h20, 1, 1, "R9");
    chk_line(0, SI, 0, 0, 0, "R8");
    xfer(0, 0, 11'h100, A_RDWB, 0, "R8");
    chk_line(0, SS, 8'h20, 1, 1, "R8");
    chk_line(1, SS, 8'h20, 1, 1, "R8");
    xfer(1, 0, 11'h104, A_NONE, 0, "R5");
    xfer(0, 1, 11'h100, A_INV, 0, "R6");
    chk_line(0, SM, 8'h20, 2, 1, "R6");
    xfer(1, 1, 11'h104, A_RIMWB, 0, "R8");
    chk_line(1, SM, 8'h20, 2, 2, "R8");
    chk_line(0, SI, 0, 0, 0, "R8");
    chk_stats('{0,2,2,0}, '{1,1,1,1}, '{3,1,3,3,10});
  endtask

  // Hits in Modified, word select, non-matching snooper.
  task automatic t_word_hits();
    do_reset();
    xfer(0, 1, 11'h10c, A_RIM, 0, "R4");
    chk_line(0, SM, 8'h21, 0, 1, "R9");
    xfer(0, 0, 11'h10c, A_NONE, 0, "R5");
    chk_line(0, SM, 8'h21, 0, 1, "R5");
    xfer(0, 1, 11'h10c, A_NONE, 0, "R5");
    chk_line(0, SM, 8'h21, 0, 2, "R5");
    xfer(0, 1, 11'h108, A_NONE, 0, "R9");
    chk_line(0, SM, 8'h21, 1, 2, "R9");
    xfer(1, 0, 11'h200, A_READ, 0, "R8");
    chk_line(0, SM, 8'h21, 1, 2, "R8");           // different tag untouched
    xfer(1, 1, 11'h204, A_INV, 0, "R6");
    chk_line(1, SM, 8'h40, 0, 1, "R6");
    chk_line(0, SM, 8'h21, 1, 2, "R8");
    chk_stats('{1,0,2,1}, '{0,1,1,0}, '{1,1,0,1,3});
    @(negedge clk);
    chk("R2", "done pulse ends", 64'(done_o), 64'd0);
  endtask

  initial begin
    t_reset_state();
    t_refill_chain();
    t_false_share();
    t_word_hits();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #500000;
    n_err++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule